// File: doc/BRIEF.md
# Block-Addressed Expected-Data Generator and Checker

This block builds the expected contents of each logical block as a stream, one byte at a time, and compares that stream with the bytes coming back from a storage device. The expected byte comes from one of two sources. One is a byte stream from an external buffer that runs beside the device data. The other is an internal 32-bit pseudo-random generator. At every block boundary the generator restarts from a seed derived from the block's own address. Any block can therefore be rebuilt on its own, and a check can begin at any address without first stepping through the blocks before it.

Inside every block, four bytes at a programmable offset are replaced by the block's 32-bit address, least significant byte first. This happens with either source. The device input never stalls. Each valid beat is compared in the cycle it arrives. The first miscompare is frozen for the host, and a saturating counter keeps counting all miscompares.

A one-cycle start pulse loads the starting block address and restarts the position count. The same pulse also clears the capture and the counter.

Top module: `lba_pattern_checker`

## Requirements
- R1: `dev_ready` is always 1. Exactly one byte is compared on each cycle with `dev_valid`=1 (and `cfg_start`=0). Cycles with `dev_valid`=0 change nothing.
- R2: With `cfg_src_gen`=0 the source byte is `buf_byte` of the same beat. With `cfg_src_gen`=1 it is the generator output.
- R3: The generator seed for a block at address A is `cfg_base_seed ^ A`, replaced by 32'h1 if that is zero. The generator output is state[7:0]. After each byte the state becomes `(s >> 1) ^ (s[0] ? 32'hD0000001 : 0)`.
- R4: A block is `cfg_blk_len` bytes long. After the last byte the position returns to 0, the address increments by one (wrapping at 2^32), and the generator is reseeded per R3.
- R5: A `cfg_start` pulse sets the position to 0, sets the address to `cfg_start_lba`, seeds the generator, and clears the flag, the captured fields and the counter. A beat in the same cycle is neither compared nor counted.
- R6: At block positions `cfg_ovl_off`+k, k=0..3, the expected byte is address bits [8k+7:8k]. This applies to both sources.
- R7: `cfg_err` is 1 exactly when `cfg_blk_len` < 4 or `cfg_ovl_off` > `cfg_blk_len` - 4. It is combinational.
- R8: `miss_count` increments by one on each miscomparing beat and saturates at all ones.
- R9: On the first miscompare after start, `miss_flag` is set and stays set. `miss_lba`, `miss_off`, `miss_exp` and `miss_act` record that beat's address, position, expected byte and actual byte. Later miscompares leave these fields unchanged.
- R10: A miscompare on the last byte of a block records the address of that block, not of the following one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start pulse: load address, restart position, clear capture |
| cfg_start_lba | input | 32 | First block address |
| cfg_base_seed | input | 32 | Base seed XORed with each block address |
| cfg_blk_len | input | 16 | Block length in bytes |
| cfg_ovl_off | input | 16 | Byte position of the address stamp |
| cfg_src_gen | input | 1 | 1 = generator source, 0 = buffer stream |
| cfg_err | output | 1 | Stamp does not fit inside the block |
| buf_byte | input | 8 | Buffer stream byte, aligned with the device beat |
| dev_valid | input | 1 | Device byte valid |
| dev_ready | output | 1 | Always 1 |
| dev_byte | input | 8 | Byte returned by the device |
| miss_flag | output | 1 | Sticky first-miscompare flag |
| miss_lba | output | 32 | Address of the first miscomparing block |
| miss_off | output | 16 | Position of the first miscompare within its block |
| miss_exp | output | 8 | Expected byte at the first miscompare |
| miss_act | output | 8 | Received byte at the first miscompare |
| miss_count | output | 32 | Saturating miscompare count |

## Verification
Two events can land in the same cycle. One is a miscompare on the final byte of a block. The other is the boundary step, which advances the address and reseeds the generator. The bench corrupts exactly that byte and checks that the capture holds the old block's address and the last position, with the expected byte taken from before the reseed. The other coincidence is a start pulse arriving together with a valid beat carrying wrong data. It is judged by a miscompare count of zero and a clean comparison of the next block from position 0.

// File: rtl/lbachk_pkg.sv
package lbachk_pkg;

    localparam int unsigned GEN_W = 32;
    localparam logic [GEN_W-1:0] GEN_TAPS = 32'hD000_0001;

    function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
        return (s >> 1) ^ (s[0] ? GEN_TAPS : '0);
    endfunction

    function automatic logic [GEN_W-1:0] gen_seed(input logic [GEN_W-1:0] base,
                                                 input logic [GEN_W-1:0] lba);
        logic [GEN_W-1:0] s;
        s = base ^ lba;
        return (s == '0) ? {{(GEN_W-1){1'b0}}, 1'b1} : s;
    endfunction

endpackage

// File: rtl/lbachk_gen.sv
module lbachk_gen
    import lbachk_pkg::*;
#(
    parameter int unsigned LBA_W  = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LBA_W-1:0]  start_lba,
    input  logic [GEN_W-1:0]  base_seed,
    input  logic [OFF_W-1:0]  blk_len,
    input  logic [OFF_W-1:0]  ovl_off,
    input  logic              src_gen,
    input  logic [BYTE_W-1:0] buf_byte,
    input  logic              beat,
    output logic [BYTE_W-1:0] exp_byte,
    output logic [LBA_W-1:0]  cur_lba,
    output logic [OFF_W-1:0]  cur_pos
);
    localparam int unsigned OVL_BYTES = LBA_W / BYTE_W;

    typedef struct packed {
        logic [OFF_W-1:0] pos;
        logic [LBA_W-1:0] lba;
        logic [GEN_W-1:0] lfsr;
    } gen_t;

    gen_t st_d, st_q;
    logic [OFF_W-1:0] rel;
    logic             last;

    always_comb begin
        rel      = st_q.pos - ovl_off;
        exp_byte = src_gen ? st_q.lfsr[BYTE_W-1:0] : buf_byte;
        for (int i = 0; i < OVL_BYTES; i++) begin
            if (st_q.pos >= ovl_off && rel == OFF_W'(i))
                exp_byte = st_q.lba[i*BYTE_W +: BYTE_W];
        end
        last = ({1'b0, st_q.pos} + 1'b1) >= {1'b0, blk_len};

        st_d = st_q;
        if (start) begin
            st_d.pos  = '0;
            st_d.lba  = start_lba;
            st_d.lfsr = gen_seed(base_seed, GEN_W'(start_lba));
        end else if (beat) begin
            if (last) begin
                st_d.pos  = '0;
                st_d.lba  = st_q.lba + 1'b1;
                st_d.lfsr = gen_seed(base_seed, GEN_W'(st_q.lba + 1'b1));
            end else begin
                st_d.pos  = st_q.pos + 1'b1;
                st_d.lfsr = gen_step(st_q.lfsr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pos: '0, lba: '0, lfsr: {{(GEN_W-1){1'b0}}, 1'b1}};
        else        st_q <= st_d;
    end

    assign cur_lba = st_q.lba;
    assign cur_pos = st_q.pos;

    // R4: the block boundary returns to position 0 with the next address
    p_boundary_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !start && last) |=> (st_q.pos == '0 && st_q.lba == $past(st_q.lba) + 1'b1));

    // R3: the generator never holds the all-zero state
    p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0);

    // R1: an idle cycle leaves the position unchanged
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat && !start) |=> $stable(st_q.pos));

endmodule

// File: rtl/lbachk_cap.sv
module lbachk_cap #(
    parameter int unsigned LBA_W  = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              beat,
    input  logic [BYTE_W-1:0] exp_byte,
    input  logic [BYTE_W-1:0] act_byte,
    input  logic [LBA_W-1:0]  cur_lba,
    input  logic [OFF_W-1:0]  cur_pos,
    output logic              flag,
    output logic [LBA_W-1:0]  cap_lba,
    output logic [OFF_W-1:0]  cap_off,
    output logic [BYTE_W-1:0] cap_exp,
    output logic [BYTE_W-1:0] cap_act,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              flag;
        logic [LBA_W-1:0]  lba;
        logic [OFF_W-1:0]  off;
        logic [BYTE_W-1:0] exp;
        logic [BYTE_W-1:0] act;
        logic [CNT_W-1:0]  cnt;
    } cap_t;

    cap_t cap_d, cap_q;
    logic mis;

    always_comb begin
        mis   = beat && (exp_byte != act_byte);
        cap_d = cap_q;
        if (clr) begin
            cap_d = '0;
        end else if (mis) begin
            if (cap_q.cnt != CNT_MAX) cap_d.cnt = cap_q.cnt + 1'b1;
            if (!cap_q.flag) begin
                cap_d.flag = 1'b1;
                cap_d.lba  = cur_lba;
                cap_d.off  = cur_pos;
                cap_d.exp  = exp_byte;
                cap_d.act  = act_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign flag    = cap_q.flag;
    assign cap_lba = cap_q.lba;
    assign cap_off = cap_q.off;
    assign cap_exp = cap_q.exp;
    assign cap_act = cap_q.act;
    assign count   = cap_q.cnt;

    // R9: the flag is sticky until a start pulse
    p_sticky_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.flag && !clr) |=> cap_q.flag);

    // R9: captured fields are frozen once the flag is set
    p_capture_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.flag && !clr) |=> ($stable(cap_q.lba) && $stable(cap_q.off)
                                  && $stable(cap_q.exp) && $stable(cap_q.act)));

    // R8: counter holds at its maximum
    p_count_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.cnt == CNT_MAX && !clr) |=> cap_q.cnt == CNT_MAX);

    // R8: a miscompare below the maximum adds exactly one
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && exp_byte != act_byte && !clr && cap_q.cnt != CNT_MAX)
            |=> cap_q.cnt == $past(cap_q.cnt) + 1'b1);

    // R5: a start pulse empties the capture
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!cap_q.flag && cap_q.cnt == '0));

endmodule

// File: rtl/lba_pattern_checker.sv
module lba_pattern_checker
    import lbachk_pkg::*;
#(
    parameter int unsigned LBA_W  = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [LBA_W-1:0]  cfg_start_lba,
    input  logic [GEN_W-1:0]  cfg_base_seed,
    input  logic [OFF_W-1:0]  cfg_blk_len,
    input  logic [OFF_W-1:0]  cfg_ovl_off,
    input  logic              cfg_src_gen,
    output logic              cfg_err,
    input  logic [BYTE_W-1:0] buf_byte,
    input  logic              dev_valid,
    output logic              dev_ready,
    input  logic [BYTE_W-1:0] dev_byte,
    output logic              miss_flag,
    output logic [LBA_W-1:0]  miss_lba,
    output logic [OFF_W-1:0]  miss_off,
    output logic [BYTE_W-1:0] miss_exp,
    output logic [BYTE_W-1:0] miss_act,
    output logic [CNT_W-1:0]  miss_count
);
    localparam logic [OFF_W-1:0] STAMP_LEN = OFF_W'(LBA_W / BYTE_W);

    logic              beat;
    logic [BYTE_W-1:0] exp_byte;
    logic [LBA_W-1:0]  cur_lba;
    logic [OFF_W-1:0]  cur_pos;

    assign dev_ready = 1'b1;
    assign beat      = dev_valid && !cfg_start;
    assign cfg_err   = (cfg_blk_len < STAMP_LEN) || (cfg_ovl_off > cfg_blk_len - STAMP_LEN);

    lbachk_gen #(.LBA_W(LBA_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cfg_start),
        .start_lba (cfg_start_lba),
        .base_seed (cfg_base_seed),
        .blk_len   (cfg_blk_len),
        .ovl_off   (cfg_ovl_off),
        .src_gen   (cfg_src_gen),
        .buf_byte  (buf_byte),
        .beat      (beat),
        .exp_byte  (exp_byte),
        .cur_lba   (cur_lba),
        .cur_pos   (cur_pos)
    );

    lbachk_cap #(.LBA_W(LBA_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_start),
        .beat     (beat),
        .exp_byte (exp_byte),
        .act_byte (dev_byte),
        .cur_lba  (cur_lba),
        .cur_pos  (cur_pos),
        .flag     (miss_flag),
        .cap_lba  (miss_lba),
        .cap_off  (miss_off),
        .cap_exp  (miss_exp),
        .cap_act  (miss_act),
        .count    (miss_count)
    );

    // R10: the first capture on a last byte holds the pre-boundary address
    p_last_byte_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !miss_flag && dev_byte != exp_byte && cur_pos == cfg_blk_len - 1'b1)
            |=> (miss_lba == $past(cur_lba) && miss_lba != cur_lba));

endmodule

// File: tb/lba_pattern_checker_tb.sv
module lba_pattern_checker_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h5EED_1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [31:0] cfg_start_lba = '0;
    logic [31:0] cfg_base_seed = BASE;
    logic [15:0] cfg_blk_len = 16'd8;
    logic [15:0] cfg_ovl_off = 16'd0;
    logic        cfg_src_gen = 1'b0;
    logic        cfg_err;
    logic [7:0]  buf_byte = '0;
    logic        dev_valid = 1'b0;
    logic        dev_ready;
    logic [7:0]  dev_byte = '0;
    logic        miss_flag;
    logic [31:0] miss_lba;
    logic [15:0] miss_off;
    logic [7:0]  miss_exp;
    logic [7:0]  miss_act;
    logic [31:0] miss_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lba_pattern_checker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_start_lba(cfg_start_lba),
        .cfg_base_seed(cfg_base_seed), .cfg_blk_len(cfg_blk_len), .cfg_ovl_off(cfg_ovl_off),
        .cfg_src_gen(cfg_src_gen), .cfg_err(cfg_err), .buf_byte(buf_byte),
        .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_byte(dev_byte),
        .miss_flag(miss_flag), .miss_lba(miss_lba), .miss_off(miss_off),
        .miss_exp(miss_exp), .miss_act(miss_act), .miss_count(miss_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_step(input logic [31:0] s);
        logic [31:0] n;
        n = {1'b0, s[31:1]};
        if (s[0]) n = n ^ 32'hD000_0001;
        return n;
    endfunction

    function automatic logic [31:0] m_seed(input logic [31:0] lba);
        return ((BASE ^ lba) == 32'h0) ? 32'h1 : (BASE ^ lba);
    endfunction

    // One pass: start pulse, nbeats compared bytes, bytes e1/e2 corrupted.
    task automatic run(input int len, input int off, input bit src, input logic [31:0] lba0,
                       input int nbeats, input int e1, input int e2, input bit start_beat);
        logic [31:0] mlba, ms;
        int mpos, nerr;
        logic [31:0] f_lba;
        int f_off;
        logic [7:0] f_exp, f_act, e, a, b;
        mlba = lba0; ms = m_seed(lba0); mpos = 0; nerr = 0;
        f_lba = '0; f_off = 0; f_exp = '0; f_act = '0;
        @(negedge clk);
        cfg_blk_len = 16'(len); cfg_ovl_off = 16'(off); cfg_src_gen = src;
        cfg_start_lba = lba0; cfg_start = 1'b1;
        dev_valid = start_beat; dev_byte = 8'hC3; buf_byte = 8'h11;
        for (int k = 0; k < nbeats; k++) begin
            if (k % 5 == 4) begin
                @(negedge clk);
                cfg_start = 1'b0; dev_valid = 1'b0; dev_byte = 8'hEE; buf_byte = 8'h77;
            end
            @(negedge clk);
            cfg_start = 1'b0;
            b = 8'(k * 37 + 11);
            e = src ? ms[7:0] : b;
            if (mpos >= off && mpos - off < 4) e = 8'(mlba >> (8 * (mpos - off)));
            a = (k == e1 || k == e2) ? (e ^ 8'h5A) : e;
            if (a != e) begin
                if (nerr == 0) begin f_lba = mlba; f_off = mpos; f_exp = e; f_act = a; end
                nerr++;
            end
            buf_byte = b; dev_byte = a; dev_valid = 1'b1;
            if (mpos == len - 1) begin mpos = 0; mlba = mlba + 1; ms = m_seed(mlba); end
            else begin mpos++; ms = m_step(ms); end
        end
        @(negedge clk);
        dev_valid = 1'b0; cfg_start = 1'b0;
        @(negedge clk);
        chk(miss_count == 32'(nerr), "R8 count (also R2/R3/R4/R5/R6/R1 data)", miss_count, nerr);
        chk(miss_flag == (nerr > 0), "R9 flag", miss_flag, nerr > 0);
        if (nerr > 0) begin
            chk(miss_lba == f_lba, "R9 lba", miss_lba, f_lba);
            chk(miss_off == 16'(f_off), "R9 off", miss_off, f_off);
            chk(miss_exp == f_exp, "R9 exp (R2/R3/R6)", miss_exp, f_exp);
            chk(miss_act == f_act, "R9 act", miss_act, f_act);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(miss_flag == 1'b0, "R9 reset flag", miss_flag, 0);
        chk(miss_count == 32'h0, "R8 reset count", miss_count, 0);
        chk(dev_ready == 1'b1, "R1 ready", dev_ready, 1);

        // R7: geometry sweep
        for (int len = 0; len <= 8; len++) begin
            for (int off = 0; off <= 9; off++) begin
                @(negedge clk);
                cfg_blk_len = 16'(len); cfg_ovl_off = 16'(off);
                #1;
                chk(cfg_err == ((len < 4) || (off > len - 4)), "R7 cfg_err", cfg_err,
                    (len < 4) || (off > len - 4));
            end
        end

        // Sweep all valid stamp positions, both sources, clean and corrupted
        for (int len = 4; len <= 7; len++) begin
            for (int off = 0; off <= len - 4; off++) begin
                for (int src = 0; src < 2; src++) begin
                    run(len, off, src[0], 32'h0000_1000 + 32'(len * 16 + off), 3 * len, -1, -1, 1'b0);
                    run(len, off, src[0], 32'hFFFF_FFFF, 3 * len, len + (off + 2) % len, 2 * len + 1, 1'b0);
                end
            end
        end

        // R10: corrupt the final byte of the first block
        run(8, 2, 1'b1, 32'h0000_0040, 16, 7, -1, 1'b0);
        run(8, 4, 1'b0, 32'h0000_0041, 16, 7, 15, 1'b0);
        // R3: start address that makes the raw seed zero
        run(6, 1, 1'b1, BASE, 12, 3, -1, 1'b0);
        // R3/R4: arbitrary start address, no preceding blocks
        run(5, 0, 1'b1, 32'h1234_5678, 15, -1, -1, 1'b0);
        // R5: beat with bad data coincides with the start pulse
        run(6, 2, 1'b1, 32'h0000_0777, 12, -1, -1, 1'b1);
        run(6, 0, 1'b0, 32'h0000_0778, 12, 0, -1, 1'b1);

        chk(dev_ready == 1'b1, "R1 ready end", dev_ready, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule